// File: doc/BRIEF.md
# Atomic 16-bit Register Bridge

This block sits between a byte-wide register bus and a bank of 16-bit peripheral registers. A byte bus cannot move 16 bits in one transfer, so a single shared staging byte joins two byte transfers into one access. To the peripheral, each access then behaves as a single indivisible read or write.

Each register occupies two bus addresses. Address bit 0 selects the byte: 0 is the low byte and 1 is the high byte. The remaining address bits hold the register index. Software writes the low byte first, and that byte is only parked in the staging byte. The high-byte write then delivers the whole word to the peripheral in one cycle.

Reads also go low byte first. A low-byte read returns the live low byte and, at the same clock edge, parks the live high byte in the staging byte. The following high-byte read returns that parked byte, so a value that changes every cycle, such as a running counter, still comes back as one coherent snapshot.

The logic is organised around two decoded operation codes, one for the write strobe and one for the read strobe. Each code takes one of three named values: IDLE (no access), LO (low-byte access) and HI (high-byte access). The staging-byte register has two transitions. A LO write loads it from the bus, and a LO read loads it from the live high byte. When both happen in the same cycle, the write wins. In every other case the staging byte holds its value.

Top module: `atomic16_bridge`

## Requirements
- R1: After reset `bus_rdata` is 0, `load_strobe` is all zero, and the staging byte is 0, so a high-byte read issued straight after reset returns 0.
- R2: A write with address bit 0 = 0 stores `bus_wdata` in the staging byte and raises no bit of `load_strobe`.
- R3: A write with address bit 0 = 1 raises exactly bit `addr[ADDR_W-1:1]` of `load_strobe` in that same cycle. In that cycle `load_data` is {`bus_wdata`, staging byte}.
- R4: A read with address bit 0 = 0 presents bits [7:0] of the addressed live word on `bus_rdata` one cycle later. At the same edge it copies bits [15:8] of that word into the staging byte.
- R5: A read with address bit 0 = 1 presents the staging byte on `bus_rdata` one cycle later, not the live high byte.
- R6: All registers share one staging byte. A low-byte write or read to one register affects a later high-byte access to any register, including a high-byte read that had no low-byte read before it.
- R7: A low-byte read followed by a high-byte read of a value that changes every cycle returns the low and high halves of the one word present at the low-byte read.
- R8: `bus_rdata` holds its last value in every cycle without a read strobe.
- R9: When the write and read strobes are both high in one cycle, both take effect. A low-byte write beats the live-high capture of a low-byte read for the staging byte. A high-byte read returns, and a high-byte write uses, the staging byte as it stood before that edge.
- R10: Register index `i` has its live value on `periph_value[16*i +: 16]` and is addressed at `2*i` (low byte) and `2*i+1` (high byte).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address: {register index, byte select} |
| bus_wdata | input | 8 | Write data byte |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| periph_value | input | 16*NUM_REGS | Live 16-bit values of all registers |
| load_data | output | 16 | Word to load into the addressed register |
| load_strobe | output | NUM_REGS | One-hot load enable, per register |

## Verification
Two functions can land in the same cycle: a write and a read with both strobes high on one address, both reaching for the staging byte. The bench provokes this with a low-byte write plus a low-byte read, then checks with a following high-byte read that the written byte, not the live high byte, was kept. It also issues a high-byte write plus a high-byte read and checks that the returned byte and the loaded low half both equal the staging byte from before that edge. The snapshot check runs against a counter that steps every cycle with carries into the high byte, so a torn read shows up as a pair that does not match the sampled word.

// File: rtl/atomic16_pkg.sv
package atomic16_pkg;

    // Decoded byte operation for one strobe
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_LO   = 2'd1,
        OP_HI   = 2'd2
    } op_e;

endpackage

// File: rtl/atomic16_decode.sv
module atomic16_decode
    import atomic16_pkg::*;
#(
    parameter int NUM_REGS = 4,
    localparam int IDX_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int ADDR_W = IDX_W + 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output logic [IDX_W-1:0]  idx,
    output op_e               wr_op,
    output op_e               rd_op
);

    logic idx_ok;
    op_e  byte_op;

    assign idx    = addr[ADDR_W-1:1];
    assign idx_ok = (int'(idx) < NUM_REGS);

    always_comb begin
        unique case (addr[0])
            1'b0: byte_op = OP_LO;
            1'b1: byte_op = OP_HI;
        endcase
    end

    assign wr_op = (wr && idx_ok) ? byte_op : OP_IDLE;
    assign rd_op = (rd && idx_ok) ? byte_op : OP_IDLE;

endmodule

// File: rtl/atomic16_temp.sv
module atomic16_temp
    import atomic16_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  op_e        wr_op,
    input  op_e        rd_op,
    input  logic [7:0] wdata,
    input  logic [7:0] live_hi,
    output logic [7:0] tmp_q
);

    logic [7:0] tmp_d;

    // Write capture has priority over read capture
    always_comb begin
        tmp_d = tmp_q;
        unique case (rd_op)
            OP_LO:   tmp_d = live_hi;
            OP_HI,
            OP_IDLE: tmp_d = tmp_q;
            default: tmp_d = tmp_q;
        endcase
        if (wr_op == OP_LO) begin
            tmp_d = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmp_q <= 8'h00;
        end else begin
            tmp_q <= tmp_d;
        end
    end

endmodule

// File: rtl/atomic16_rdport.sv
module atomic16_rdport
    import atomic16_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  op_e        rd_op,
    input  logic [7:0] live_lo,
    input  logic [7:0] tmp_q,
    output logic [7:0] rdata_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= 8'h00;
        end else begin
            unique case (rd_op)
                OP_LO:   rdata_q <= live_lo;
                OP_HI:   rdata_q <= tmp_q;
                OP_IDLE: rdata_q <= rdata_q;
                default: rdata_q <= rdata_q;
            endcase
        end
    end

endmodule

// File: rtl/atomic16_bridge.sv
module atomic16_bridge
    import atomic16_pkg::*;
#(
    parameter int NUM_REGS = 4,
    localparam int IDX_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int ADDR_W = IDX_W + 1,
    localparam int VAL_W  = 16 * NUM_REGS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [7:0]          bus_wdata,
    input  logic                bus_wr,
    input  logic                bus_rd,
    output logic [7:0]          bus_rdata,
    input  logic [VAL_W-1:0]    periph_value,
    output logic [15:0]         load_data,
    output logic [NUM_REGS-1:0] load_strobe
);

    logic [IDX_W-1:0] idx;
    op_e              wr_op;
    op_e              rd_op;
    logic [7:0]       tmp_q;
    logic [15:0]      live_sel;
    logic [15:0]      live_arr [NUM_REGS];

    atomic16_decode #(.NUM_REGS(NUM_REGS)) decode_i (
        .addr  (bus_addr),
        .wr    (bus_wr),
        .rd    (bus_rd),
        .idx   (idx),
        .wr_op (wr_op),
        .rd_op (rd_op)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_REGS; g++) begin : g_reg
            assign live_arr[g]    = periph_value[16*g +: 16];
            assign load_strobe[g] = (wr_op == OP_HI) && (idx == IDX_W'(g));
        end
    endgenerate

    always_comb begin
        live_sel = 16'h0000;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (idx == IDX_W'(i)) begin
                live_sel = live_arr[i];
            end
        end
    end

    atomic16_temp temp_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_op   (wr_op),
        .rd_op   (rd_op),
        .wdata   (bus_wdata),
        .live_hi (live_sel[15:8]),
        .tmp_q   (tmp_q)
    );

    atomic16_rdport rdport_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_op   (rd_op),
        .live_lo (live_sel[7:0]),
        .tmp_q   (tmp_q),
        .rdata_q (bus_rdata)
    );

    assign load_data = {bus_wdata, tmp_q};

    // Assertions guarding the bridge
    assert_load_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_strobe));

    assert_lowwr_noload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr[0]) |-> (load_strobe == '0));

    assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    assert_hiread_temp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[0] && (int'(bus_addr[ADDR_W-1:1]) < NUM_REGS))
        |=> (bus_rdata == $past(tmp_q)));

    assert_lowwr_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr[0] && (int'(bus_addr[ADDR_W-1:1]) < NUM_REGS))
        |=> (load_data[7:0] == $past(bus_wdata)));

endmodule

// File: tb/atomic16_bridge_tb.sv
module atomic16_bridge_tb_top;

    localparam int CLK_P  = 10;
    localparam int NREG   = 4;
    localparam int AW     = 3;

    typedef struct {
        logic [7:0] v;
        string      tag;
    } rd_item_t;

    typedef struct {
        int          idx;
        logic [15:0] d;
        string       tag;
    } ld_item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic [7:0]        bus_wdata = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [7:0]        bus_rdata;
    logic [16*NREG-1:0] periph_value;
    logic [15:0]       load_data;
    logic [NREG-1:0]   load_strobe;

    logic [15:0] cnt = 16'h12F0;
    logic [15:0] live1 = 16'h0000;
    logic [15:0] live2 = 16'h0000;
    logic [15:0] live3 = 16'h0000;

    rd_item_t rd_q[$];
    ld_item_t ld_q[$];
    logic [7:0] exp_tmp = 8'h00;
    logic rd_pend = 1'b0;
    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    assign periph_value = {live3, live2, live1, cnt};

    atomic16_bridge #(.NUM_REGS(NREG)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_rdata    (bus_rdata),
        .periph_value (periph_value),
        .load_data    (load_data),
        .load_strobe  (load_strobe)
    );

    always #(CLK_P/2) clk = ~clk;

    // Running counter on register 0, carries into the high byte often
    always @(posedge clk) cnt <= cnt + 16'h0081;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] live_of(input int i);
        return periph_value[16*i +: 16];
    endfunction

    // Driver: applies one access and pushes expected results
    task automatic op(input bit w, input bit r, input int idx, input bit hi,
                      input logic [7:0] wd, input string tag);
        logic [15:0] lv;
        @(negedge clk);
        lv = live_of(idx);
        bus_addr  = AW'({idx[AW-2:0], hi});
        bus_wdata = wd;
        bus_wr    = w;
        bus_rd    = r;
        if (r) begin
            rd_item_t it;
            it.v   = hi ? exp_tmp : lv[7:0];
            it.tag = tag;
            rd_q.push_back(it);
        end
        if (w && hi) begin
            ld_item_t li;
            li.idx = idx;
            li.d   = {wd, exp_tmp};
            li.tag = tag;
            ld_q.push_back(li);
        end
        if (r && !hi) exp_tmp = lv[15:8];
        if (w && !hi) exp_tmp = wd;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            bus_wr = 1'b0;
            bus_rd = 1'b0;
        end
    endtask

    // Monitor: pops and compares as results appear
    always begin
        @(negedge clk);
        if (rd_pend) begin
            if (rd_q.size() == 0) begin
                check(1'b0, "R4 read with no expectation", 32'(bus_rdata), 32'h0);
            end else begin
                rd_item_t it;
                it = rd_q.pop_front();
                check(bus_rdata === it.v, it.tag, 32'(bus_rdata), 32'(it.v));
            end
        end
        #(CLK_P/4);
        rd_pend = rst_n && bus_rd;
        if (rst_n && (|load_strobe)) begin
            if (ld_q.size() == 0) begin
                check(1'b0, "R2 unexpected load", 32'(load_strobe), 32'h0);
            end else begin
                ld_item_t li;
                li = ld_q.pop_front();
                check(load_strobe === NREG'(1 << li.idx), li.tag, 32'(load_strobe), 32'(1 << li.idx));
                check(load_data === li.d, li.tag, 32'(load_data), 32'(li.d));
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 20000);
        check(1'b0, "watchdog", 32'h0, 32'h1);
        finish_run();
    end

    initial begin
        logic [7:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(bus_rdata === 8'h00, "R1 rdata at reset", 32'(bus_rdata), 32'h0);
        check(load_strobe === '0, "R1 strobe at reset", 32'(load_strobe), 32'h0);
        rst_n = 1'b1;
        op(0, 1, 1, 1, 8'h00, "R1 staging byte zero after reset");
        idle(1);
        @(negedge clk);
        live1 = 16'hBEEF; live2 = 16'h1234; live3 = 16'hA55A;
        // R2: low write stores only; R6: high read without low read gives staging byte
        op(1, 0, 1, 0, 8'h3C, "R2 low write");
        op(0, 1, 1, 1, 8'h00, "R6 high read returns staging not live");
        // R3: high write loads {wdata, staging}
        op(1, 0, 1, 1, 8'h77, "R3 high write reg1");
        op(1, 0, 3, 0, 8'h11, "R2 low write reg3");
        op(1, 0, 3, 1, 8'h22, "R10 R3 high write reg3");
        // R6: shared staging byte across registers
        op(1, 0, 2, 0, 8'h99, "R6 low write reg2");
        op(1, 0, 3, 1, 8'h44, "R6 high write reg3 uses reg2 low");
        // R4, R5: read pair with live change between
        op(0, 1, 1, 0, 8'h00, "R4 low read reg1");
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        live1 = 16'h0102;
        op(0, 1, 1, 1, 8'h00, "R5 high read gives captured byte");
        // R4: low read captures live high, then high write uses it
        op(0, 1, 3, 0, 8'h00, "R4 low read reg3");
        op(1, 0, 3, 1, 8'h01, "R4 captured high into load");
        // R7: coherent snapshots of running counter
        for (int k = 0; k < 24; k++) begin
            op(0, 1, 0, 0, 8'h00, "R7 snapshot low");
            op(0, 1, 0, 1, 8'h00, "R7 snapshot high");
            if (k % 3 == 0) idle(1);
        end
        // R8: rdata holds without read
        op(0, 1, 2, 0, 8'h00, "R8 read before hold");
        idle(1);
        held = 8'h34;
        idle(3);
        check(bus_rdata === held, "R8 rdata holds", 32'(bus_rdata), 32'(held));
        // R9: simultaneous strobes
        op(1, 1, 2, 0, 8'h5A, "R9 low read with low write");
        op(0, 1, 2, 1, 8'h00, "R9 write wins staging byte");
        op(1, 0, 0, 0, 8'hC3, "R9 set staging");
        op(1, 1, 1, 1, 8'h66, "R9 high read with high write");
        idle(4);
        check(rd_q.size() == 0 && ld_q.size() == 0, "R3 all expected results seen",
              32'(rd_q.size() + ld_q.size()), 32'h0);
        finish_run();
    end

endmodule